// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a byte-wide asynchronous serial port that sits on a simple 32-bit register bus with byte addresses and word-aligned registers. Software writes a byte to the data register to send it as one 8N1 frame on the transmit line. When the stop bit has left the pin, a sticky transmit event is raised. On the receive side, a byte that arrives intact is captured into the data register and raises a sticky receive event. The captured byte stays in place until software clears that event. There is no buffering: a frame that completes while the receive event is still pending is thrown away.

Both events are cleared by writing a one to their status bit. A single level interrupt combines each event with its own enable bit in the control register. Bit timing on both directions comes from a divisor register, and one bit lasts divisor+1 clock cycles. The control register also holds a pass-through enable bit, and a debug register holds a break enable bit. Both are only stored and read back. They have no effect on the serial lines.

Top module: `event_uart`

## Requirements
- R1: Word offsets are fixed: 0x0 is data, 0x4 is divisor, 0x8 is status, 0xC is control and 0x10 is debug. Divisor, control and debug read back all 32 written bits. Reading data returns the last received byte in bits 7:0 and zero above. Offsets 0x14 and higher read 0, and writes to them change nothing.
- R2: After reset, every register reads 0 except status, which reads 0x1. Status bit 0 (transmit holding empty) always reads 1.
- R3: Status bit 1 is the receive event and bit 2 is the transmit event. Writing status clears each of these two bits where the written value is 1. Written bits that are 0, and all other written bits, have no effect.
- R4: The `irq` output equals (control bit 0 AND receive event) OR (control bit 1 AND transmit event). It follows any change of those bits in the same cycle.
- R5: A write to data while idle sends bits 7:0 as a frame on `txLine`: a low start bit, eight data bits LSB first, then a high stop bit. Each bit lasts divisor+1 cycles. The start bit begins in the cycle after the write, and the line idles high.
- R6: The transmit event is set when the stop bit completes, and not earlier.
- R7: A write to data while a frame is being sent is ignored: no extra frame is sent and the frame in flight is unchanged.
- R8: `rxLine` passes through a two-flop synchroniser and is sampled at mid-bit. A valid frame stores its byte in data and sets the receive event.
- R9: A frame is dropped, with no event and no change to data, when its start bit is high again at mid-bit or its stop bit samples low. After a low stop bit, the receiver waits for the line to return high before it looks for the next start bit.
- R10: A frame that completes while the receive event is set is discarded, and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address; bits above bit 1 pick the register |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irq | output | 1 | Level interrupt |
| txLine | output | 1 | Serial transmit line, idle high |
| rxLine | input | 1 | Serial receive line, asynchronous |

## Verification
The bench sends a second data write a few cycles into a frame. A design that honours that write would show a second frame, or corrupt the first, on the decoded line. The bench lets a second frame arrive while the receive event is pending. An unbuffered design that overwrote the held byte would read back the new byte. The bench also sends a short start glitch and a frame with a low stop bit. A receiver without a mid-bit start check, or one that ignores framing, would raise a receive event for either. The bench writes the status register with a zero in one event bit and a one in the other. A design that cleared too much would lose an event, and a design that cleared too little would leave `irq` stuck high.

// File: rtl/event_uart_pkg.sv
package event_uart_pkg;

  // word indices of the registers (byte offset / 4)
  localparam int REG_DATA = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_CTRL = 3;
  localparam int REG_DBG  = 4;

  // status and control bit positions
  localparam int ST_THRE  = 0;
  localparam int ST_RXEVT = 1;
  localparam int ST_TXEVT = 2;
  localparam int CT_RXIEN = 0;
  localparam int CT_TXIEN = 1;

  // control -> datapath strobes
  typedef struct packed {
    logic       txLaunch;
    logic [7:0] txByte;
    logic       rxAccept;
  } ctrlStrobe_t;

  // datapath -> control strobes
  typedef struct packed {
    logic       txBusy;
    logic       txDone;
    logic       rxValid;
    logic [7:0] rxByte;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rxState_t;

endpackage

// File: rtl/event_uart_ctrl.sv
module event_uart_ctrl
  import event_uart_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic [DIV_W-1:0]  divisor,
  output ctrlStrobe_t       stbOut,
  input  dpStrobe_t         dpIn
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic [7:0]       rxData;
  logic [31:0]      divReg, ctrlReg, dbgReg;
  logic             rxEvt, txEvt;
  logic             statWr;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign statWr  = busWr && (wordIdx == IDX_W'(REG_STAT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData  <= '0;
      divReg  <= '0;
      ctrlReg <= '0;
      dbgReg  <= '0;
      rxEvt   <= 1'b0;
      txEvt   <= 1'b0;
    end else begin
      if (busWr && wordIdx == IDX_W'(REG_DIV))  divReg  <= busWrData;
      if (busWr && wordIdx == IDX_W'(REG_CTRL)) ctrlReg <= busWrData;
      if (busWr && wordIdx == IDX_W'(REG_DBG))  dbgReg  <= busWrData;
      // a newly arriving event wins over a clear in the same cycle
      if (dpIn.rxValid) begin
        rxData <= dpIn.rxByte;
        rxEvt  <= 1'b1;
      end else if (statWr && busWrData[ST_RXEVT]) begin
        rxEvt <= 1'b0;
      end
      if (dpIn.txDone)                             txEvt <= 1'b1;
      else if (statWr && busWrData[ST_TXEVT])      txEvt <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    case (wordIdx)
      IDX_W'(REG_DATA): busRdData = {24'b0, rxData};
      IDX_W'(REG_DIV):  busRdData = divReg;
      IDX_W'(REG_STAT): busRdData = {29'b0, txEvt, rxEvt, 1'b1};
      IDX_W'(REG_CTRL): busRdData = ctrlReg;
      IDX_W'(REG_DBG):  busRdData = dbgReg;
      default:          busRdData = '0;
    endcase
  end

  assign irq = (ctrlReg[CT_RXIEN] & rxEvt) | (ctrlReg[CT_TXIEN] & txEvt);
  assign divisor = divReg[DIV_W-1:0];

  assign stbOut.txLaunch = busWr && (wordIdx == IDX_W'(REG_DATA)) && !dpIn.txBusy;
  assign stbOut.txByte   = busWrData[7:0];
  assign stbOut.rxAccept = !rxEvt;

endmodule

// File: rtl/event_uart_dp.sv
module event_uart_dp
  import event_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  ctrlStrobe_t      stbIn,
  output dpStrobe_t        stbOut,
  output logic             txLine,
  input  logic             rxLine
);

  localparam int FRAME_BITS = 10;

  // ---------------- transmitter ----------------
  logic                  txBusy, txDone;
  logic [FRAME_BITS-1:0] txShift;
  logic [3:0]            txBit;
  logic [DIV_W-1:0]      txCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txDone  <= 1'b0;
      txShift <= '1;
      txBit   <= '0;
      txCnt   <= '0;
    end else begin
      txDone <= 1'b0;
      if (!txBusy) begin
        if (stbIn.txLaunch) begin
          txBusy  <= 1'b1;
          txShift <= {1'b1, stbIn.txByte, 1'b0};
          txBit   <= '0;
          txCnt   <= '0;
        end
      end else if (txCnt >= divisor) begin
        txCnt <= '0;
        if (txBit == 4'(FRAME_BITS - 1)) begin
          txBusy <= 1'b0;
          txDone <= 1'b1;
        end else begin
          txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
          txBit   <= txBit + 4'd1;
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // ---------------- receiver ----------------
  logic             rxS1, rxS2;
  rxState_t         rxState;
  logic [DIV_W-1:0] rxCnt, halfBit;
  logic [2:0]       rxBit;
  logic [7:0]       rxShift;
  logic             rxValid;

  assign halfBit = divisor >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxS1    <= 1'b1;
      rxS2    <= 1'b1;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxValid <= 1'b0;
    end else begin
      rxS1    <= rxLine;
      rxS2    <= rxS1;
      rxValid <= 1'b0;
      case (rxState)
        RX_IDLE: if (!rxS2) begin
          rxState <= RX_START;
          rxCnt   <= '0;
        end
        RX_START: if (rxCnt >= halfBit) begin
          rxCnt   <= '0;
          rxBit   <= '0;
          rxState <= rxS2 ? RX_IDLE : RX_DATA;
        end else rxCnt <= rxCnt + 1'b1;
        RX_DATA: if (rxCnt >= divisor) begin
          rxCnt   <= '0;
          rxShift <= {rxS2, rxShift[7:1]};
          if (rxBit == 3'd7) rxState <= RX_STOP;
          else               rxBit   <= rxBit + 3'd1;
        end else rxCnt <= rxCnt + 1'b1;
        RX_STOP: if (rxCnt >= divisor) begin
          rxCnt <= '0;
          if (rxS2) begin
            rxState <= RX_IDLE;
            rxValid <= stbIn.rxAccept;
          end else begin
            rxState <= RX_WAITHI;
          end
        end else rxCnt <= rxCnt + 1'b1;
        RX_WAITHI: if (rxS2) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign stbOut.txBusy  = txBusy;
  assign stbOut.txDone  = txDone;
  assign stbOut.rxValid = rxValid;
  assign stbOut.rxByte  = rxShift;

endmodule

// File: rtl/event_uart.sv
module event_uart
  import event_uart_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic              txLine,
  input  logic              rxLine
);

  ctrlStrobe_t      ctrlStb;
  dpStrobe_t        dpStb;
  logic [DIV_W-1:0] divisor;

  event_uart_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .divisor(divisor), .stbOut(ctrlStb), .dpIn(dpStb)
  );

  event_uart_dp #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .divisor(divisor), .stbIn(ctrlStb),
    .stbOut(dpStb), .txLine(txLine), .rxLine(rxLine)
  );

endmodule

// File: rtl/event_uart_chk.sv
module event_uart_chk
  import event_uart_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              irq,
  input logic              txLine,
  input ctrlStrobe_t       ctrlStb,
  input dpStrobe_t         dpStb
);

  localparam int IDX_W = ADDR_W - 2;

  logic statSel;
  assign statSel = (busAddr[ADDR_W-1:2] == IDX_W'(REG_STAT));

  p_thre_r2: assert property (@(posedge clk) disable iff (!rstN)
    statSel |-> busRdData[ST_THRE]);

  p_start_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.txLaunch |=> !txLine);

  p_rx_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStb.rxAccept && !busWr) |=> !ctrlStb.rxAccept);

  p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && statSel && busWrData[ST_RXEVT] && !dpStb.rxValid) |=> ctrlStb.rxAccept);

  p_irq_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && !dpStb.txDone && !dpStb.rxValid) |=> $stable(irq));

  p_rx_discard_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStb.rxAccept |-> !dpStb.rxValid);

endmodule

bind event_uart event_uart_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
  .txLine(txLine), .ctrlStb(ctrlStb), .dpStb(dpStb)
);

// File: tb/event_uart_test.sv
`timescale 1ns/1ps
module event_uart_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq, txLine;
  logic        rxLine = 1'b1;

  int total = 0;
  int bad = 0;
  int tbDiv = 7;
  int txFrames = 0;
  int txErr = 0;
  logic [7:0] lastTx = '0;

  always #5 clk = ~clk;

  event_uart uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .txLine(txLine), .rxLine(rxLine)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic expIrq(input logic [1:0] en, input logic rxE, input logic txE);
    return (en[0] & rxE) | (en[1] & txE);
  endfunction

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // decode frames on txLine at mid-bit
  initial begin
    logic [7:0] b;
    logic startOk, stopOk;
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        repeat ((tbDiv + 1) / 2) @(negedge clk);
        startOk = (txLine === 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (tbDiv + 1) @(negedge clk);
          b[i] = txLine;
        end
        repeat (tbDiv + 1) @(negedge clk);
        stopOk = (txLine === 1'b1);
        lastTx = b;
        txFrames++;
        if (!startOk || !stopOk) txErr++;
      end
    end
  end

  task automatic rxSend(input logic [7:0] b, input bit badStart, input bit badStop);
    @(negedge clk);
    if (badStart) begin
      rxLine = 1'b0;
      waitCycles(2);
      rxLine = 1'b1;
      waitCycles(3 * (tbDiv + 1));
      return;
    end
    rxLine = 1'b0;
    waitCycles(tbDiv + 1);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      waitCycles(tbDiv + 1);
    end
    rxLine = !badStop;
    waitCycles(tbDiv + 1);
    rxLine = 1'b1;
    waitCycles(2 * (tbDiv + 1));
  endtask

  task automatic setDiv(input int d);
    tbDiv = d;
    busWrite(8'h04, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    int frames0;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(1);

    // R2 reset state
    busRead(8'h00, r); chk("R2 data reset", r, 32'h0);
    busRead(8'h04, r); chk("R2 divisor reset", r, 32'h0);
    busRead(8'h08, r); chk("R2 status reset", r, 32'h1);
    busRead(8'h0C, r); chk("R2 control reset", r, 32'h0);
    busRead(8'h10, r); chk("R2 debug reset", r, 32'h0);
    chk("R2 irq reset", irq, 1'b0);
    chk("R2 txLine idle", txLine, 1'b1);

    // R1 register map
    busWrite(8'h04, 32'h1234_5678);
    busWrite(8'h0C, 32'hA5A5_A5A4);
    busWrite(8'h10, 32'hDEAD_BEEF);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busRead(8'h04, r); chk("R1 divisor rw", r, 32'h1234_5678);
    busRead(8'h0C, r); chk("R1 control rw", r, 32'hA5A5_A5A4);
    busRead(8'h10, r); chk("R1 debug rw", r, 32'hDEAD_BEEF);
    busRead(8'h14, r); chk("R1 beyond map reads 0", r, 32'h0);
    busRead(8'h20, r); chk("R1 far offset reads 0", r, 32'h0);
    busRead(8'h08, r); chk("R1 status unaffected", r, 32'h1);
    chk("R1 line untouched by mode bits", txLine, 1'b1);
    busWrite(8'h0C, 32'h0);
    busWrite(8'h10, 32'h0);

    // R5/R6 transmit
    setDiv(7);
    frames0 = txFrames;
    busWrite(8'h00, 32'h0000_01A5);
    waitCycles(5 * 8);
    busRead(8'h08, r); chk("R6 no event mid-frame", r, 32'h1);
    waitCycles(6 * 8);
    chk("R5 one frame", txFrames - frames0, 1);
    chk("R5 frame byte", lastTx, 8'hA5);
    chk("R5 framing", txErr, 0);
    busRead(8'h08, r); chk("R6 tx event after stop", r, 32'h5);

    // R7 write while busy ignored
    busWrite(8'h08, 32'h4);
    frames0 = txFrames;
    busWrite(8'h00, 32'h3C);
    waitCycles(2);
    busWrite(8'h00, 32'hFF);
    waitCycles(14 * 8);
    chk("R7 single frame", txFrames - frames0, 1);
    chk("R7 byte unchanged", lastTx, 8'h3C);

    // R3 write-one-to-clear, R4 irq
    busRead(8'h08, r); chk("R3 tx event set", r, 32'h5);
    busWrite(8'h0C, 32'h2);
    chk("R4 irq tx enabled", irq, 1'b1);
    busWrite(8'h0C, 32'h1);
    chk("R4 irq tx masked", irq, 1'b0);
    busWrite(8'h08, 32'hFFFF_FFF9);
    busRead(8'h08, r); chk("R3 zero bit keeps tx event", r, 32'h5);
    busWrite(8'h08, 32'h4);
    busRead(8'h08, r); chk("R3 clear tx event", r, 32'h1);

    // R8 receive
    rxSend(8'h6B, 0, 0);
    busRead(8'h08, r); chk("R8 rx event", r, 32'h3);
    busRead(8'h00, r); chk("R8 rx byte", r, 32'h6B);
    chk("R4 irq rx enabled", irq, 1'b1);
    // R10 discard while pending
    rxSend(8'h99, 0, 0);
    busRead(8'h00, r); chk("R10 held byte kept", r, 32'h6B);
    busWrite(8'h08, 32'h4);
    busRead(8'h08, r); chk("R3 tx-clear leaves rx event", r, 32'h3);
    busWrite(8'h08, 32'h2);
    busRead(8'h08, r); chk("R3 clear rx event", r, 32'h1);
    chk("R4 irq drops", irq, 1'b0);
    busRead(8'h00, r); chk("R10 discarded byte absent", r, 32'h6B);

    // R9 framing faults
    rxSend(8'h00, 1, 0);
    busRead(8'h08, r); chk("R9 start glitch dropped", r, 32'h1);
    rxSend(8'h44, 0, 1);
    busRead(8'h08, r); chk("R9 bad stop dropped", r, 32'h1);
    busRead(8'h00, r); chk("R9 data unchanged", r, 32'h6B);
    rxSend(8'h44, 0, 0);
    busRead(8'h00, r); chk("R8 recovery byte", r, 32'h44);
    busWrite(8'h08, 32'h6);

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 12; it++) begin
      logic [7:0] tb, rb;
      logic [1:0] en;
      int d;
      d  = 3 + ($urandom % 10);
      tb = 8'($urandom);
      rb = 8'($urandom);
      en = 2'($urandom);
      setDiv(d);
      busWrite(8'h0C, {30'b0, en});
      frames0 = txFrames;
      busWrite(8'h00, {24'b0, tb});
      waitCycles(11 * (d + 1) + 4);
      chk("R5 random frame", lastTx, tb);
      chk("R5 random count", txFrames - frames0, 1);
      busRead(8'h08, r); chk("R6 random tx event", r, 32'h5);
      chk("R4 random irq tx", irq, expIrq(en, 1'b0, 1'b1));
      rxSend(rb, 0, 0);
      busRead(8'h00, r); chk("R8 random rx byte", r, {24'b0, rb});
      busRead(8'h08, r); chk("R8 random status", r, 32'h7);
      chk("R4 random irq both", irq, expIrq(en, 1'b1, 1'b1));
      busWrite(8'h08, 32'h6);
      busRead(8'h08, r); chk("R3 random clear", r, 32'h1);
      chk("R4 random irq clear", irq, 1'b0);
    end
    chk("R5 framing overall", txErr, 0);

    finishRun();
  end

endmodule